// File: doc/BRIEF.md
# Serial response receiver

This block sits on the master side of a two-wire serial link made up of a clock line and a shared data line. After the command side has sent a request, the receiver takes over. It turns the data line around so that the master no longer drives it, and it generates the bus clock one bit slot at a time. It samples the returning frame, whose data line is active low. First it looks for a start bit within a bounded number of slots. It then reads a two-bit responder address and a two-bit response code. A data field follows only when the response is an acknowledge and a read of 1, 2 or 4 bytes is pending. A four-bit check code closes the frame.

At the end of the frame the block reports the response code, the address and the read data, together with two error flags. One flag marks a missing response (timeout) and the other a failed check code. These results are qualified by a one-cycle done pulse. Retry after a busy response and any follow-up commands belong to the surrounding controller.

Top module: `rsp_rx`

## Requirements
- R1: Out of reset and while idle: `bclk_o` is high, `sda_oe_o` and `dir_out_o` are high, `busy_o` and `done_o` are low, and all result outputs are zero.
- R2: From the cycle after an accepted `start_i` until done, `sda_oe_o` and `dir_out_o` are low. `bclk_o` spends one cycle low and then one cycle high per bit slot. `sda_i` is sampled at the clock edge that ends each high cycle.
- R3: A low level on `sda_i` is received as logic 1 and a high level as logic 0.
- R4: The receiver hunts for a start bit (a received 1) for at most `TMO_BITS` slots. A start bit in slot `TMO_BITS` is still accepted.
- R5: If no start bit arrives within `TMO_BITS` slots, `done_o` pulses exactly 2*`TMO_BITS` cycles after the start edge. `err_timeout_o` is set, and `tag_o`, `id_o`, `data_o` and `err_crc_o` are zero.
- R6: After the start bit, the first two received bits (MSB first) form `id_o` and the next two form `tag_o`. Tag codes: 0 acknowledge, 1 busy, 2 general error, 3 responder saw a bad command check code.
- R7: Data bits are received only when the tag is 0 and `size_i` (latched at start) is nonzero. Size codes: 0 none, 1 = 8 bits, 2 = 16 bits, 3 = 32 bits. Otherwise `data_o` is zero and the frame is 1+4+4 bits long. `done_o` rises 2*(lead slots + frame bits) cycles after the start edge.
- R8: Read data is right-aligned in `data_o`, zero-extended, with the first received bit (and so the first byte) most significant.
- R9: The check code uses polynomial x^4+x+1 (`CRC_POLY`=4'h3), an all-zero initial value and MSB-first shifting. It runs over the start bit, address, tag, data and the four received check bits. A nonzero remainder sets `err_crc_o`.
- R10: `done_o` is a one-cycle pulse. The results hold until the next accepted start. `start_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin reception (accepted only when idle) |
| size_i | input | 2 | Expected read size code |
| sda_i | input | 1 | Serial data line, active low |
| bclk_o | output | 1 | Bus clock, idles high |
| sda_oe_o | output | 1 | Master data driver enable (low while receiving) |
| dir_out_o | output | 1 | Level translator direction, 1 = outbound |
| busy_o | output | 1 | Reception in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| tag_o | output | 2 | Response code |
| id_o | output | 2 | Responder address |
| data_o | output | 32 | Read data |
| err_timeout_o | output | 1 | No start bit within the hunt window |
| err_crc_o | output | 1 | Check code remainder nonzero |

## Verification
On every cycle the assertions check the line handover while busy, the alternation of the bus clock, and the idle levels. They also check that done lasts one cycle, that results stay stable while idle, and that a timeout lands exactly at the end of the hunt window with clean results. Only the bench's scenarios can show that the captured address, tag and data match what the responder sent, and that the frame length depends on tag and size. The same holds for detection of a corrupted check code and for the acceptance of a start bit in the last hunt slot.

// File: rtl/rsp_rx_pkg.sv
package rsp_rx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
  localparam int unsigned HDR_BITS = 4;
  localparam int unsigned CHK_BITS = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_HDR, ST_DATA, ST_CHK
  } rx_state_e;

  typedef enum logic [1:0] {
    TAG_ACK     = 2'd0,
    TAG_BUSY    = 2'd1,
    TAG_ERR_GEN = 2'd2,
    TAG_ERR_CHK = 2'd3
  } rsp_tag_e;

  function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] sz);
    case (sz)
      2'd1:    data_bits = CNT_W'(8);
      2'd2:    data_bits = CNT_W'(16);
      2'd3:    data_bits = CNT_W'(32);
      default: data_bits = '0;
    endcase
  endfunction

  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b,
                                           input logic [3:0] poly);
    logic fb;
    fb = c[3] ^ b;
    crc4_step = {c[2:0], 1'b0} ^ (fb ? poly : 4'h0);
  endfunction
endpackage

// File: rtl/rsp_rx_bitclk.sv
module rsp_rx_bitclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic bclk_o,
  output logic strobe_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= 1'b0;
    else if (!en_i) phase_q <= 1'b0;
    else            phase_q <= ~phase_q;
  end

  // low half first, sample at end of high half
  assign bclk_o   = ~(en_i & ~phase_q);
  assign strobe_o = en_i & phase_q;
endmodule

// File: rtl/rsp_rx_crc.sv
module rsp_rx_crc
  import rsp_rx_pkg::*;
#(
  parameter logic [3:0] CRC_POLY = 4'h3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       step_i,
  input  logic       bit_i,
  output logic [3:0] nxt_o
);
  logic [3:0] rem_q;

  assign nxt_o = crc4_step(rem_q, bit_i, CRC_POLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (clr_i)  rem_q <= '0;
    else if (step_i) rem_q <= nxt_o;
  end
endmodule

// File: rtl/rsp_rx_ctrl.sv
module rsp_rx_ctrl
  import rsp_rx_pkg::*;
#(
  parameter int unsigned TMO_BITS = 1000,
  localparam int unsigned HUNT_W = $clog2(TMO_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              bit_i,
  input  logic              strobe_i,
  input  logic [3:0]        crc_nxt_i,
  output logic              busy_o,
  output logic              crc_clr_o,
  output logic              crc_step_o,
  output logic              done_o,
  output logic [1:0]        tag_o,
  output logic [1:0]        id_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_timeout_o,
  output logic              err_crc_o
);
  rx_state_e         state_q;
  logic [HUNT_W-1:0] hunt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        hdr_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] shreg_q;
  logic [1:0]        tag_now;
  logic [CNT_W-1:0]  dlast;

  assign busy_o     = (state_q != ST_IDLE);
  assign crc_clr_o  = start_i && (state_q == ST_IDLE);
  assign crc_step_o = strobe_i && ((state_q != ST_HUNT) || bit_i);
  assign tag_now    = {hdr_q[0], bit_i};
  assign dlast      = data_bits(size_q) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      hunt_q        <= '0;
      cnt_q         <= '0;
      hdr_q         <= '0;
      size_q        <= '0;
      shreg_q       <= '0;
      done_o        <= 1'b0;
      tag_o         <= '0;
      id_o          <= '0;
      data_o        <= '0;
      err_timeout_o <= 1'b0;
      err_crc_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q       <= ST_HUNT;
            hunt_q        <= '0;
            cnt_q         <= '0;
            hdr_q         <= '0;
            size_q        <= size_i;
            shreg_q       <= '0;
            tag_o         <= '0;
            id_o          <= '0;
            data_o        <= '0;
            err_timeout_o <= 1'b0;
            err_crc_o     <= 1'b0;
          end
        end
        ST_HUNT: begin
          if (strobe_i) begin
            if (bit_i) begin
              state_q <= ST_HDR;
              cnt_q   <= '0;
            end else if (hunt_q == HUNT_W'(TMO_BITS - 1)) begin
              state_q       <= ST_IDLE;
              done_o        <= 1'b1;
              err_timeout_o <= 1'b1;
            end else begin
              hunt_q <= hunt_q + HUNT_W'(1);
            end
          end
        end
        ST_HDR: begin
          if (strobe_i) begin
            hdr_q <= {hdr_q[1:0], bit_i};
            if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
              id_o  <= hdr_q[2:1];
              tag_o <= tag_now;
              cnt_q <= '0;
              if (tag_now == TAG_ACK && size_q != 2'd0) state_q <= ST_DATA;
              else                                      state_q <= ST_CHK;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (strobe_i) begin
            shreg_q <= {shreg_q[DATA_W-2:0], bit_i};
            if (cnt_q == dlast) begin
              state_q <= ST_CHK;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_CHK: begin
          if (strobe_i) begin
            if (cnt_q == CNT_W'(CHK_BITS - 1)) begin
              state_q   <= ST_IDLE;
              done_o    <= 1'b1;
              err_crc_o <= (crc_nxt_i != 4'h0);
              data_o    <= shreg_q;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsp_rx.sv
module rsp_rx
  import rsp_rx_pkg::*;
#(
  parameter int unsigned TMO_BITS = 1000,
  parameter logic [3:0]  CRC_POLY = 4'h3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  size_i,
  input  logic        sda_i,
  output logic        bclk_o,
  output logic        sda_oe_o,
  output logic        dir_out_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  tag_o,
  output logic [1:0]  id_o,
  output logic [31:0] data_o,
  output logic        err_timeout_o,
  output logic        err_crc_o
);
  logic       strobe;
  logic       rx_bit;
  logic       crc_clr;
  logic       crc_step;
  logic [3:0] crc_nxt;

  assign rx_bit    = ~sda_i;  // line is active low
  assign sda_oe_o  = ~busy_o;
  assign dir_out_o = ~busy_o;

  rsp_rx_bitclk u_bitclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (busy_o),
    .bclk_o   (bclk_o),
    .strobe_o (strobe)
  );

  rsp_rx_crc #(.CRC_POLY(CRC_POLY)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .step_i (crc_step),
    .bit_i  (rx_bit),
    .nxt_o  (crc_nxt)
  );

  rsp_rx_ctrl #(.TMO_BITS(TMO_BITS)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .size_i        (size_i),
    .bit_i         (rx_bit),
    .strobe_i      (strobe),
    .crc_nxt_i     (crc_nxt),
    .busy_o        (busy_o),
    .crc_clr_o     (crc_clr),
    .crc_step_o    (crc_step),
    .done_o        (done_o),
    .tag_o         (tag_o),
    .id_o          (id_o),
    .data_o        (data_o),
    .err_timeout_o (err_timeout_o),
    .err_crc_o     (err_crc_o)
  );
endmodule

// File: rtl/rsp_rx_chk.sv
module rsp_rx_chk #(
  parameter int unsigned TMO_BITS = 1000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        bclk_o,
  input logic        sda_oe_o,
  input logic        dir_out_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [1:0]  tag_o,
  input logic [1:0]  id_o,
  input logic [31:0] data_o,
  input logic        err_timeout_o,
  input logic        err_crc_o
);
  int unsigned cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cyc_q <= 0;
    else if (start_i && !busy_o)  cyc_q <= 0;
    else if (busy_o)              cyc_q <= cyc_q + 1;
  end

  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (bclk_o && sda_oe_o && dir_out_o));

  p_rx_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!sda_oe_o && !dir_out_o));

  p_bclk_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (bclk_o != $past(bclk_o)));

  p_tmo_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_timeout_o) |-> (cyc_q == 2 * TMO_BITS));

  p_tmo_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_timeout_o) |-> (tag_o == 2'd0 && id_o == 2'd0 &&
                                   data_o == '0 && !err_crc_o));

  p_nodata_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && tag_o != 2'd0) |-> (data_o == '0));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(tag_o) && $stable(id_o) &&
                               $stable(data_o) && $stable(err_crc_o) &&
                               $stable(err_timeout_o)));
endmodule

bind rsp_rx rsp_rx_chk #(.TMO_BITS(TMO_BITS)) u_rsp_rx_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .bclk_o        (bclk_o),
  .sda_oe_o      (sda_oe_o),
  .dir_out_o     (dir_out_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .tag_o         (tag_o),
  .id_o          (id_o),
  .data_o        (data_o),
  .err_timeout_o (err_timeout_o),
  .err_crc_o     (err_crc_o)
);

// File: tb/rsp_rx_bench.sv
module rsp_rx_bench;
  localparam int TMO = 1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic        sda_i = 1'b1;
  logic        bclk_o, sda_oe_o, dir_out_o, busy_o, done_o;
  logic [1:0]  tag_o, id_o;
  logic [31:0] data_o;
  logic        err_timeout_o, err_crc_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_cyc = 0;
  logic [63:0] fr;
  int fr_len = 0;
  int lead = 0;
  int slot = 0;
  int last_cyc = 0;

  always #2 clk_i = ~clk_i;

  rsp_rx #(.TMO_BITS(TMO)) u_rsp_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .size_i(size_i),
    .sda_i(sda_i), .bclk_o(bclk_o), .sda_oe_o(sda_oe_o), .dir_out_o(dir_out_o),
    .busy_o(busy_o), .done_o(done_o), .tag_o(tag_o), .id_o(id_o),
    .data_o(data_o), .err_timeout_o(err_timeout_o), .err_crc_o(err_crc_o)
  );

  // responder model: new bit while bus clock is low
  initial begin
    forever begin
      @(negedge clk_i);
      if (busy_o && !bclk_o) begin
        logic b;
        if (slot < lead) b = 1'b0;
        else if (slot - lead < fr_len) b = fr[fr_len - 1 - (slot - lead)];
        else b = 1'b0;
        sda_i = ~b;
        slot++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      n_cyc++;
      if (n_cyc > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=<190000", n_cyc);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] sz);
    case (sz)
      2'd1: return 8;
      2'd2: return 16;
      2'd3: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] poly_step(input logic [3:0] c, input logic b);
    logic [3:0] r;
    r = {c[2:0], 1'b0};
    if (c[3] != b) r = r ^ 4'b0011;
    return r;
  endfunction

  task automatic push(input logic b);
    fr = {fr[62:0], b};
    fr_len++;
  endtask

  task automatic run(input logic [1:0] sz, input logic [1:0] id,
                     input logic [1:0] tag, input logic [31:0] dat,
                     input bit bad_chk, input int ld, input bit mid_start);
    int d;
    logic [3:0] c;
    fr = '0; fr_len = 0;
    push(1'b1);
    push(id[1]); push(id[0]); push(tag[1]); push(tag[0]);
    d = (tag == 2'd0) ? nbits(sz) : 0;
    for (int i = d - 1; i >= 0; i--) push(dat[i]);
    c = 4'h0;
    for (int i = 0; i < fr_len; i++) c = poly_step(c, fr[fr_len - 1 - i]);
    if (bad_chk) c = c ^ 4'h1;
    for (int i = 3; i >= 0; i--) push(c[i]);
    lead = ld;
    slot = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    size_i  = sz;
    @(negedge clk_i);
    start_i = 1'b0;
    last_cyc = 1;
    // R2: line released and clock low in first slot
    chk(busy_o && !sda_oe_o && !dir_out_o && !bclk_o, "R2 release",
        {busy_o, sda_oe_o, dir_out_o, bclk_o}, 4'b1000);
    while (!done_o && last_cyc < 5000) begin
      @(negedge clk_i);
      last_cyc++;
      start_i = mid_start && (last_cyc == 10);
      if (mid_start && last_cyc == 10) size_i = ~sz;
    end
    start_i = 1'b0;
  endtask

  initial begin
    logic [31:0] dat;
    logic [31:0] exp_d;
    int flen;
    repeat (4) @(negedge clk_i);
    chk(bclk_o && sda_oe_o && dir_out_o && !busy_o && !done_o, "R1 idle lines",
        {bclk_o, sda_oe_o, dir_out_o, busy_o, done_o}, 5'b11100);
    chk(tag_o == 0 && id_o == 0 && data_o == 0 && !err_timeout_o && !err_crc_o,
        "R1 reset results", data_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(bclk_o && !busy_o, "R1 idle after reset", {bclk_o, busy_o}, 2'b10);

    // sweep every size, address and tag
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 4; a++) begin
        for (int t = 0; t < 4; t++) begin
          dat = 32'h9D3C_6A51 ^ (32'h0101_0101 * (s * 16 + a * 4 + t));
          run(2'(s), 2'(a), 2'(t), dat, 1'b0, 3, 1'b0);
          exp_d = (t == 0 && s != 0) ? (dat & ((64'd1 << nbits(2'(s))) - 1)) : 0;
          flen = 9 + ((t == 0) ? nbits(2'(s)) : 0);
          chk(done_o, "R10 done seen", done_o, 1);
          chk(id_o == 2'(a), "R6 R3 id", id_o, a);
          chk(tag_o == 2'(t), "R6 R3 tag", tag_o, t);
          chk(data_o == exp_d, "R7 R8 data", data_o, exp_d);
          chk(!err_crc_o && !err_timeout_o, "R9 clean frame",
              {err_crc_o, err_timeout_o}, 0);
          chk(last_cyc == 2 * (3 + flen) + 1, "R7 frame length", last_cyc,
              2 * (3 + flen) + 1);
          @(negedge clk_i);
          chk(!done_o, "R10 done one cycle", done_o, 0);
        end
      end
    end

    // byte order
    run(2'd3, 2'd1, 2'd0, 32'h1122_3344, 1'b0, 0, 1'b0);
    chk(data_o == 32'h1122_3344, "R8 four byte order", data_o, 32'h1122_3344);
    run(2'd2, 2'd2, 2'd0, 32'hFFFF_BEEF, 1'b0, 0, 1'b0);
    chk(data_o == 32'h0000_BEEF, "R8 two byte align", data_o, 32'h0000_BEEF);

    // corrupted check code
    for (int s = 0; s < 4; s++) begin
      run(2'(s), 2'd3, 2'd0, 32'hC0DE_F00D, 1'b1, 1, 1'b0);
      chk(err_crc_o && !err_timeout_o, "R9 bad code ack",
          {err_crc_o, err_timeout_o}, 2'b10);
    end
    run(2'd1, 2'd0, 2'd2, 32'h0, 1'b1, 1, 1'b0);
    chk(err_crc_o, "R9 bad code err tag", err_crc_o, 1);

    // hunt window boundary
    run(2'd1, 2'd2, 2'd0, 32'h0000_005A, 1'b0, TMO - 1, 1'b0);
    chk(!err_timeout_o && data_o == 32'h5A && id_o == 2'd2, "R4 last slot start",
        data_o, 32'h5A);
    run(2'd1, 2'd2, 2'd0, 32'h0000_005A, 1'b0, TMO, 1'b0);
    chk(err_timeout_o && !err_crc_o, "R5 timeout flag",
        {err_timeout_o, err_crc_o}, 2'b10);
    chk(tag_o == 0 && id_o == 0 && data_o == 0, "R5 timeout results", data_o, 0);
    chk(last_cyc == 2 * TMO + 1, "R5 timeout time", last_cyc, 2 * TMO + 1);

    // result hold and start ignored while busy
    run(2'd2, 2'd1, 2'd0, 32'h0000_A1B2, 1'b0, 2, 1'b1);
    chk(data_o == 32'hA1B2 && id_o == 2'd1 && !err_crc_o, "R10 start while busy",
        data_o, 32'hA1B2);
    repeat (12) @(negedge clk_i);
    chk(!busy_o && data_o == 32'hA1B2 && id_o == 2'd1 && tag_o == 0,
        "R10 results held", data_o, 32'hA1B2);
    chk(bclk_o && sda_oe_o && dir_out_o, "R1 idle after frame",
        {bclk_o, sda_oe_o, dir_out_o}, 3'b111);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule